// File: doc/BRIEF.md
# Serial Mode-Control Register Port

This block receives configuration words for a stereo audio interpolation path over a write-only three-wire serial link: a latch strobe, a shift clock and a data line. All three inputs are asynchronous to the system clock. They are synchronised, and their edges are detected in the system clock domain. While the strobe is low, each rising edge of the shift clock moves one data bit into a shift register, most significant bit first. A rising edge of the strobe then commits the word, but only if exactly sixteen bits were shifted since the previous commit.

Two bits of each word select one of four targets. Two targets carry per-channel attenuation codes, each with a load flag. The other two are configuration registers. These drive the mute, de-emphasis, oversampling ratio, input format, output word length, channel polarity, roll-off, clock-divide, de-emphasis rate and attenuator-linking outputs.

Attenuation codes are first written to staging registers. The active levels seen by the datapath change only when a word with its load flag set is committed, so both channels can be updated in one event.

Top module: `serial_mode_ctrl`

## Requirements
- R1: A word is sixteen bits sent MSB first. One bit is taken per rising shift-clock edge while the strobe is low. The word takes effect on the next rising strobe edge.
- R2: If a word had fewer or more than sixteen shift-clock edges before the strobe rises, it is dropped and every output keeps its value.
- R3: Word bits [10:9] select the target: 0 = left attenuation, 1 = right attenuation, 2 = config A, 3 = config B. Bits [15:11] are ignored. A write changes only its own target.
- R4: After reset the outputs are:
  - both active attenuation codes FFh (0 dB);
  - mute off and de-emphasis off;
  - 8x oversampling;
  - input format 000;
  - output length 00;
  - polarity 0, linking 0, sharp roll-off, clock undivided;
  - de-emphasis rate 00 (44.1 kHz).
- R5: Target 0 stages the left code from bits [7:0]. When bit 8 is 1, the active left code takes the new code. When bit 8 is 0, the active codes are unchanged.
- R6: Target 1 stages the right code from bits [7:0]. When bit 8 is 1, the active right code takes the new code. When bit 8 is 0, the active codes are unchanged.
- R7: With linking off, a left load also sets the active right code to the staged right code. A right load also sets the active left code to the staged left code.
- R8: With linking on (config B bit 2 = 1), a left load sets both active codes to the new left code. A right load sets both active codes to the staged left code. Code 00h passes through unchanged, meaning full mute.
- R9: Config A fields are:
  - bit 0: active-low mute; mute_o = 1 when the bit is 0;
  - bit 1: de-emphasis enable;
  - bit 2: 4x oversampling when 1, 8x when 0;
  - bits [4:3]: input word length code;
  - bits [6:5]: output word length code.
- R10: Config B fields are:
  - bit 0: I2S-style input; in_fmt_o = {bit 0, config A bits [4:3]};
  - bit 1: channel clock polarity;
  - bit 2: attenuator linking;
  - bit 3: slow roll-off;
  - bit 4: clock output divided by two;
  - bits [6:5]: de-emphasis rate, where 00 = 44.1 kHz, 01 = reserved, 10 = 48 kHz and 11 = 32 kHz.
- R11: A change of the linking bit alone does not change the active attenuation codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Latch strobe, asynchronous |
| sclk_i | input | 1 | Shift clock, asynchronous |
| sdata_i | input | 1 | Serial data, asynchronous |
| atten_l_o | output | 8 | Active left attenuation code |
| atten_r_o | output | 8 | Active right attenuation code |
| mute_o | output | 1 | Soft mute on |
| deemph_en_o | output | 1 | De-emphasis enable |
| os4x_o | output | 1 | 4x oversampling select |
| in_fmt_o | output | 3 | Input format {i2s, length code} |
| out_len_o | output | 2 | Output word length code |
| lr_pol_o | output | 1 | Channel clock polarity |
| atten_link_o | output | 1 | Attenuator linking mode |
| slow_rolloff_o | output | 1 | Slow roll-off select |
| clk_div2_o | output | 1 | Clock output divide-by-two |
| deemph_rate_o | output | 2 | De-emphasis rate code |

## Verification
The bench uses the default parameters: a 16-bit word, two synchroniser stages and 8-bit codes. It holds each shift-clock phase for three system clocks, so the synchronised edges are clean. With a 16-bit word, both off-by-one lengths can be driven directly: fifteen and seventeen edges. With 8-bit codes, the boundary values 00h and FFh appear on the outputs. The load cases cover:
- left and right loads with linking off;
- left and right loads with linking on;
- a change of the linking bit with no load.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam int WORD_W   = 16;
  localparam int ATT_W    = 8;
  localparam int CFG_W    = 7;
  localparam int ADDR_LSB = 9;
  localparam int LOAD_BIT = 8;

  typedef enum logic [1:0] {
    TGT_ATT_L = 2'd0,
    TGT_ATT_R = 2'd1,
    TGT_CFG_A = 2'd2,
    TGT_CFG_B = 2'd3
  } tgt_e;

  // config A bit positions
  localparam int A_MUTE_N = 0;
  localparam int A_DEEMPH = 1;
  localparam int A_OS4X   = 2;
  localparam int A_IW_LSB = 3;
  localparam int A_OW_LSB = 5;
  // config B bit positions
  localparam int B_I2S    = 0;
  localparam int B_LRPOL  = 1;
  localparam int B_LINK   = 2;
  localparam int B_SLOW   = 3;
  localparam int B_DIV2   = 4;
  localparam int B_SF_LSB = 5;

  localparam logic [CFG_W-1:0] CFG_A_RST = 7'b000_0001;
  localparam logic [CFG_W-1:0] CFG_B_RST = 7'b000_0000;
endpackage

// File: rtl/smc_sync.sv
module smc_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  logic [N-1:0] pipe_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) pipe_q[s] <= '0;
    end else begin
      pipe_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/smc_shifter.sv
module smc_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  output logic              wr_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

  logic              strobe_q, sclk_q;
  logic              strobe_rise, sclk_rise;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] shreg_q;

  assign strobe_rise = strobe_i & ~strobe_q;
  assign sclk_rise   = sclk_i & ~sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b1;
      sclk_q   <= 1'b0;
      cnt_q    <= '0;
      shreg_q  <= '0;
      wr_o     <= 1'b0;
      word_o   <= '0;
    end else begin
      strobe_q <= strobe_i;
      sclk_q   <= sclk_i;
      wr_o     <= 1'b0;
      if (strobe_rise) begin
        cnt_q <= '0;
        if (cnt_q == CNT_FULL) begin
          wr_o   <= 1'b1;
          word_o <= shreg_q;
        end
      end else if (sclk_rise && !strobe_i) begin
        shreg_q <= {shreg_q[WORD_W-2:0], sdata_i};
        if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assert_wr_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !wr_o);
  assert_bad_len_dropped_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_rise && cnt_q != CNT_FULL) |=> !wr_o);
endmodule

// File: rtl/smc_cfg_regs.sv
module smc_cfg_regs
  import smc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  tgt_e             tgt_i,
  input  logic [CFG_W-1:0] data_i,
  output logic [CFG_W-1:0] cfg_a_o,
  output logic [CFG_W-1:0] cfg_b_o
);
  logic [CFG_W-1:0] cfg_q [2];

  for (genvar g = 0; g < 2; g++) begin : g_cfg
    localparam tgt_e             MY_TGT = (g == 0) ? TGT_CFG_A : TGT_CFG_B;
    localparam logic [CFG_W-1:0] MY_RST = (g == 0) ? CFG_A_RST : CFG_B_RST;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_q[g] <= MY_RST;
      else if (wr_i && tgt_i == MY_TGT) cfg_q[g] <= data_i;
    end

    assert_cfg_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_i && tgt_i == MY_TGT) |=> $stable(cfg_q[g]));
  end

  assign cfg_a_o = cfg_q[0];
  assign cfg_b_o = cfg_q[1];
endmodule

// File: rtl/smc_atten.sv
module smc_atten
  import smc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  tgt_e             tgt_i,
  input  logic [ATT_W-1:0] code_i,
  input  logic             load_i,
  input  logic             link_i,
  output logic [ATT_W-1:0] act_l_o,
  output logic [ATT_W-1:0] act_r_o
);
  logic [ATT_W-1:0] stg_l_q, stg_r_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_l_q <= '1;
      stg_r_q <= '1;
      act_l_o <= '1;
      act_r_o <= '1;
    end else if (wr_i) begin
      unique case (tgt_i)
        TGT_ATT_L: begin
          stg_l_q <= code_i;
          if (load_i) begin
            act_l_o <= code_i;
            act_r_o <= link_i ? code_i : stg_r_q;
          end
        end
        TGT_ATT_R: begin
          stg_r_q <= code_i;
          if (load_i) begin
            act_l_o <= stg_l_q;
            act_r_o <= link_i ? stg_l_q : code_i;
          end
        end
        default: ;
      endcase
    end
  end

  assert_link_left_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && load_i && link_i && tgt_i == TGT_ATT_L) |=> (act_r_o == act_l_o));
  assert_level_needs_load_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({act_l_o, act_r_o}) |-> $past(wr_i && load_i));
endmodule

// File: rtl/serial_mode_ctrl.sv
module serial_mode_ctrl
  import smc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic             sclk_i,
  input  logic             sdata_i,
  output logic [ATT_W-1:0] atten_l_o,
  output logic [ATT_W-1:0] atten_r_o,
  output logic             mute_o,
  output logic             deemph_en_o,
  output logic             os4x_o,
  output logic [2:0]       in_fmt_o,
  output logic [1:0]       out_len_o,
  output logic             lr_pol_o,
  output logic             atten_link_o,
  output logic             slow_rolloff_o,
  output logic             clk_div2_o,
  output logic [1:0]       deemph_rate_o
);
  logic [2:0]        sync_lvl;
  logic              wr;
  logic [WORD_W-1:0] word;
  tgt_e              tgt;
  logic [CFG_W-1:0]  cfg_a, cfg_b;
  logic              unused_bits;

  smc_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({strobe_i, sclk_i, sdata_i}),
    .sync_o (sync_lvl)
  );

  smc_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(sync_lvl[2]),
    .sclk_i  (sync_lvl[1]),
    .sdata_i (sync_lvl[0]),
    .wr_o    (wr),
    .word_o  (word)
  );

  assign tgt         = tgt_e'(word[ADDR_LSB +: 2]);
  assign unused_bits = ^{word[WORD_W-1:ADDR_LSB+2], word[ATT_W-1:CFG_W]};

  smc_cfg_regs u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr),
    .tgt_i  (tgt),
    .data_i (word[CFG_W-1:0]),
    .cfg_a_o(cfg_a),
    .cfg_b_o(cfg_b)
  );

  smc_atten u_att (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr),
    .tgt_i  (tgt),
    .code_i (word[ATT_W-1:0]),
    .load_i (word[LOAD_BIT]),
    .link_i (cfg_b[B_LINK]),
    .act_l_o(atten_l_o),
    .act_r_o(atten_r_o)
  );

  assign mute_o         = ~cfg_a[A_MUTE_N];
  assign deemph_en_o    = cfg_a[A_DEEMPH];
  assign os4x_o         = cfg_a[A_OS4X];
  assign in_fmt_o       = {cfg_b[B_I2S], cfg_a[A_IW_LSB +: 2]};
  assign out_len_o      = cfg_a[A_OW_LSB +: 2];
  assign lr_pol_o       = cfg_b[B_LRPOL];
  assign atten_link_o   = cfg_b[B_LINK];
  assign slow_rolloff_o = cfg_b[B_SLOW];
  assign clk_div2_o     = cfg_b[B_DIV2];
  assign deemph_rate_o  = cfg_b[B_SF_LSB +: 2];
endmodule

// File: tb/tb_serial_mode_ctrl.sv
module tb_serial_mode_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic strobe = 1'b1, sclk = 1'b0, sdata = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0] atl, atr;
  logic       mute, deemph, os4x, lrpol, link, slow, div2;
  logic [2:0] infmt;
  logic [1:0] olen, sf;

  serial_mode_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .sclk_i(sclk), .sdata_i(sdata),
    .atten_l_o(atl), .atten_r_o(atr), .mute_o(mute), .deemph_en_o(deemph),
    .os4x_o(os4x), .in_fmt_o(infmt), .out_len_o(olen), .lr_pol_o(lrpol),
    .atten_link_o(link), .slow_rolloff_o(slow), .clk_div2_o(div2),
    .deemph_rate_o(sf)
  );

  logic [29:0] dut_vec;
  assign dut_vec = {atl, atr, mute, deemph, os4x, infmt, olen, lrpol, link, slow, div2, sf};

  typedef struct { logic [29:0] v; string tag; } exp_t;
  exp_t q[$];
  int   n_chk = 0, n_fail = 0;
  bit   done = 0;

  // reference state built from the requirements
  logic [7:0] stg_l = 8'hFF, stg_r = 8'hFF, act_l = 8'hFF, act_r = 8'hFF;
  logic [6:0] cfg_a = 7'h01, cfg_b = 7'h00;

  function automatic logic [29:0] model_vec();
    return {act_l, act_r, ~cfg_a[0], cfg_a[1], cfg_a[2], cfg_b[0], cfg_a[4:3],
            cfg_a[6:5], cfg_b[1], cfg_b[2], cfg_b[3], cfg_b[4], cfg_b[6:5]};
  endfunction

  function automatic void model_apply(logic [15:0] w);
    case (w[10:9])
      2'd0: begin
        stg_l = w[7:0];
        if (w[8]) begin act_l = w[7:0]; act_r = cfg_b[2] ? w[7:0] : stg_r; end
      end
      2'd1: begin
        stg_r = w[7:0];
        if (w[8]) begin act_l = stg_l; act_r = cfg_b[2] ? stg_l : w[7:0]; end
      end
      2'd2: cfg_a = w[6:0];
      default: cfg_b = w[6:0];
    endcase
  endfunction

  task automatic push_exp(string tag);
    exp_t e;
    e.v = model_vec();
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic send(logic [15:0] w, int nclk, string tag);
    @(posedge clk); strobe = 1'b0;
    repeat (3) @(posedge clk);
    for (int i = 0; i < nclk; i++) begin
      sdata = (i < 16) ? w[15-i] : 1'b0;
      repeat (3) @(posedge clk); sclk = 1'b1;
      repeat (3) @(posedge clk); sclk = 1'b0;
    end
    repeat (3) @(posedge clk); strobe = 1'b1;
    if (nclk == 16) model_apply(w);
    repeat (10) @(posedge clk);
    push_exp(tag);
  endtask

  // monitor: compares each queued expectation away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (dut_vec !== e.v) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", e.tag, dut_vec, e.v);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    push_exp("R4 reset defaults");
    send(16'h0080, 16, "R5 stage left without load");
    send(16'h0180, 16, "R5 R7 left load, right from staged");
    send(16'h0240, 16, "R6 stage right without load");
    send(16'h0010, 16, "R5 stage left 10h");
    send(16'h0340, 16, "R6 R7 right load, left from staged");
    send(16'h045A, 16, "R9 config A fields");
    send(16'h067B, 16, "R10 R3 config B fields, config A kept");
    send(16'h0604, 16, "R11 link on without load");
    send(16'h0100, 16, "R8 left load 00h mutes both");
    send(16'h0033, 16, "R8 stage left 33h");
    send(16'h03EE, 16, "R8 right load uses staged left");
    send(16'h0400, 15, "R2 short word dropped");
    send(16'h0400, 17, "R2 long word dropped");
    send(16'hF9FF, 16, "R1 R3 reserved bits ignored, left load FFh");
    send(16'h0600, 16, "R1 link off after recovery");
    send(16'h0311, 16, "R7 right load unlinked");
    repeat (4) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule